// File: doc/BRIEF.md
# Programmable Trigger Crossbar with Edge Requests

This block connects a set of single-bit trigger sources to a set of single-bit trigger destinations. Each destination has its own 8-bit select field naming the source it follows. The routed value is registered, so a destination shows its source one clock after the source changes. A select value that names no existing source drives a constant 0.

The lowest four destinations also carry an edge watcher. Each watcher can look for a rising edge, a falling edge or both. When it sees the chosen edge it latches a status flag. If requests are enabled, that flag is presented either as an interrupt request or as a DMA request. Software clears a flag by writing a one to it. In DMA mode, an acknowledge pulse on that destination's DMA acknowledge line also clears it.

All configuration goes through a plain 16-bit register port. Writes take effect at a clock edge, and reads are combinational from the current address.

Top module: `trig_crossbar`

## Requirements
- R1: After reset every destination output is 0, every register reads 0x0000, and no interrupt or DMA request is asserted.
- R2: For a select value below N_IN (16 by default), destination j shows source `in_trig[sel_j]` one clock after that value is presented. With a 16-bit register write, the new select is in use from the clock edge that follows the write edge.
- R3: Select register k (address k, for k below N_OUT/2) holds the select of destination 2k in bits [7:0] and the select of destination 2k+1 in bits [15:8]. Reading it returns both fields as written.
- R4: A select value greater than or equal to N_IN drives a constant 0 onto that destination, whatever the sources do.
- R5: Control register c (address N_OUT/2 + c, which is 4 or 5 by default) holds the control byte of destination 2c in bits [7:0] and of destination 2c+1 in bits [15:8]. Within a byte, bits [1:0] are the edge mode (00 off, 01 rising, 10 falling, 11 both), bit 2 enables requests, bit 3 selects DMA (1) or interrupt (0), and bit 4 is the status flag. Bits [7:5] are ignored on write and read as 0.
- R6: A flag sets at the clock edge after the routed destination output shows an edge that matches its mode. This is the second edge after the source changes. Mode 00, or a non-matching edge, never sets it.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An edge detected in the same cycle as the clearing write leaves the flag set.
- R8: With requests enabled, a set flag drives `irq_req` in interrupt mode or `dma_req` in DMA mode, never both. With requests disabled the flag still sets but neither request asserts.
- R9: In DMA mode with requests enabled, a `dma_ack` pulse clears that destination's flag and request at the next edge. In interrupt mode `dma_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_trig | input | N_IN (16) | Trigger sources |
| reg_addr | input | ADDR_W (4) | Register address (16-bit word index) |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| out_trig | output | N_OUT (8) | Registered routed destinations |
| irq_req | output | N_EDGE (4) | Interrupt requests, one per edge-capable destination |
| dma_req | output | N_EDGE (4) | DMA requests, one per edge-capable destination |
| dma_ack | input | N_EDGE (4) | DMA acknowledge pulses |

## Verification
On every cycle, the assertions check four things. Each destination carries the source its select named one cycle earlier. An out-of-range select gives 0. A matching edge always leaves the flag set, and a flag with no clear pending stays set. A DMA acknowledge in enabled DMA mode clears the flag, and the two request kinds are never raised together.

Some behaviour can only be shown by the bench's scenarios. These include the byte-lane packing of the registers and the read-back value of the status bits. They also include the exact two-edge latency from a source change to a flag, a clearing write that lands in the same cycle as an edge, and an acknowledge that has no effect in interrupt mode.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

    localparam int SEL_W    = 8;
    localparam int FLAG_POS = 4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic       dma_sel;
        logic       req_en;
        edge_mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/trig_xbar_mux.sv
module trig_xbar_mux #(
    parameter int N_IN  = 16,
    parameter int SEL_W = 8
) (
    input  logic [N_IN-1:0]  in_vec,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    always_comb begin
        if (sel < SEL_W'(N_IN)) y = in_vec[sel[IDX_W-1:0]];
        else                    y = 1'b0;
    end
endmodule

// File: rtl/trig_xbar_edge.sv
module trig_xbar_edge
    import trig_xbar_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sig_now,
    input  ctrl_t cfg,
    input  logic  clr_w1c,
    input  logic  dma_ack,
    output logic  flag,
    output logic  irq,
    output logic  dma
);
    typedef struct packed {
        logic prev;
        logic flag;
    } state_t;

    state_t st_d, st_q;
    logic   hit;
    logic   clear;

    always_comb begin
        case (cfg.mode)
            EDGE_RISE: hit =  sig_now & ~st_q.prev;
            EDGE_FALL: hit = ~sig_now &  st_q.prev;
            EDGE_BOTH: hit =  sig_now ^  st_q.prev;
            default:   hit = 1'b0;
        endcase
        clear     = clr_w1c | (dma_ack & cfg.req_en & cfg.dma_sel);
        st_d.prev = sig_now;
        st_d.flag = hit | (st_q.flag & ~clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & cfg.req_en & ~cfg.dma_sel;
    assign dma  = st_q.flag & cfg.req_en &  cfg.dma_sel;

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == EDGE_RISE && sig_now && !st_q.prev) |=> st_q.flag); // R6
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == EDGE_FALL && !sig_now && st_q.prev) |=> st_q.flag); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_w1c && !dma_ack) |=> st_q.flag); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && cfg.req_en && cfg.dma_sel && cfg.mode == EDGE_OFF) |=> !st_q.flag); // R9
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma)); // R8
endmodule

// File: rtl/trig_crossbar.sv
module trig_crossbar
    import trig_xbar_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_OUT  = 8,
    parameter int N_EDGE = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_trig,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [N_OUT-1:0]  out_trig,
    output logic [N_EDGE-1:0] irq_req,
    output logic [N_EDGE-1:0] dma_req,
    input  logic [N_EDGE-1:0] dma_ack
);
    localparam int N_SEL_REG  = N_OUT / 2;
    localparam int N_CTRL_REG = N_EDGE / 2;
    localparam int CTRL_BASE  = N_SEL_REG;
    localparam int IDX_W      = (N_IN > 1) ? $clog2(N_IN) : 1;

    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] sel;
        ctrl_t [N_EDGE-1:0]          ctrl;
        logic [N_OUT-1:0]            out;
    } state_t;

    state_t              st_d, st_q;
    logic [N_OUT-1:0]    routed;
    logic [N_EDGE-1:0]   w1c;
    logic [N_EDGE-1:0]   flags;
    logic                unused_bits;

    assign unused_bits = ^{reg_wdata[7:5], reg_wdata[15:13]};

    for (genvar j = 0; j < N_OUT; j++) begin : g_route
        trig_xbar_mux #(.N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
            .in_vec (in_trig),
            .sel    (st_q.sel[j]),
            .y      (routed[j])
        );

        AST_ROUTE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.sel[j] < SEL_W'(N_IN)) |=>
            (out_trig[j] == $past(in_trig[st_q.sel[j][IDX_W-1:0]]))); // R2
        AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.sel[j] >= SEL_W'(N_IN)) |=> !out_trig[j]); // R4
    end

    for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
        trig_xbar_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_now (st_q.out[i]),
            .cfg     (st_q.ctrl[i]),
            .clr_w1c (w1c[i]),
            .dma_ack (dma_ack[i]),
            .flag    (flags[i]),
            .irq     (irq_req[i]),
            .dma     (dma_req[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.out = routed;
        w1c      = '0;
        if (reg_wr) begin
            for (int k = 0; k < N_SEL_REG; k++) begin
                if (reg_addr == ADDR_W'(k)) begin
                    st_d.sel[2*k]   = reg_wdata[7:0];
                    st_d.sel[2*k+1] = reg_wdata[15:8];
                end
            end
            for (int i = 0; i < N_EDGE; i++) begin
                if (reg_addr == ADDR_W'(CTRL_BASE + i/2)) begin
                    st_d.ctrl[i] = ctrl_t'(reg_wdata[(i%2)*8 +: CTRL_W]);
                    w1c[i]       = reg_wdata[(i%2)*8 + FLAG_POS];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_SEL_REG; k++) begin
            if (reg_addr == ADDR_W'(k))
                reg_rdata = {st_q.sel[2*k+1], st_q.sel[2*k]};
        end
        for (int c = 0; c < N_CTRL_REG; c++) begin
            if (reg_addr == ADDR_W'(CTRL_BASE + c))
                reg_rdata = {3'b000, flags[2*c+1], st_q.ctrl[2*c+1],
                             3'b000, flags[2*c],   st_q.ctrl[2*c]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_trig = st_q.out;

    AST_NO_REQ_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req | dma_req) & ~flags) == '0); // R8
endmodule

// File: tb/trig_crossbar_test.sv
module trig_crossbar_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_trig = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  out_trig;
    logic [3:0]  irq_req, dma_req;
    logic [3:0]  dma_ack = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_crossbar uut (
        .clk(clk), .rst_n(rst_n), .in_trig(in_trig), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_trig(out_trig), .irq_req(irq_req), .dma_req(dma_req), .dma_ack(dma_ack)
    );

    typedef struct packed {
        logic [15:0] sel;
        logic [15:0] inp;
        logic [1:0]  exp;
        logic        oor;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'h0100, 16'h0001, 2'b01, 1'b0},
        '{16'h0100, 16'h0002, 2'b10, 1'b0},
        '{16'h0F05, 16'h8020, 2'b11, 1'b0},
        '{16'h0F05, 16'h0020, 2'b01, 1'b0},
        '{16'h100F, 16'hFFFF, 2'b01, 1'b1},
        '{16'hFF0A, 16'hFFFF, 2'b01, 1'b1},
        '{16'h0A0A, 16'h0400, 2'b11, 1'b0},
        '{16'h0300, 16'h0008, 2'b10, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack_pulse(input logic [3:0] m);
        @(negedge clk);
        dma_ack = m;
        @(negedge clk);
        dma_ack = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 out", {24'h0, out_trig}, 32'h0);
        chk("R1 irq", {28'h0, irq_req}, 32'h0);
        chk("R1 dma", {28'h0, dma_req}, 32'h0);
        rd(4'd0, rv); chk("R1 sel reg", {16'h0, rv}, 32'h0);
        rd(4'd4, rv); chk("R1 ctrl reg", {16'h0, rv}, 32'h0);

        // R2 / R4 routing table
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            in_trig = VECS[v].inp;
            wr(4'd0, VECS[v].sel);
            @(negedge clk);
            chk(VECS[v].oor ? "R4 route" : "R2 route", {30'h0, out_trig[1:0]}, {30'h0, VECS[v].exp});
            rd(4'd0, rv);
            chk("R3 readback", {16'h0, rv}, {16'h0, VECS[v].sel});
        end

        // R3 odd/even lanes on last select register
        wr(4'd0, 16'h0100);
        wr(4'd1, 16'h0302);
        wr(4'd3, 16'h0201);
        @(negedge clk); in_trig = 16'h0004;
        wait_n(2);
        chk("R3 lanes", {30'h0, out_trig[7:6]}, 32'h2);
        rd(4'd3, rv); chk("R3 reg3", {16'h0, rv}, 32'h0201);
        @(negedge clk); in_trig = 16'h0000;
        wait_n(3);

        // R5 control packing and ignored bits
        wr(4'd4, 16'h0F05);
        rd(4'd4, rv); chk("R5 ctrl0", {16'h0, rv}, 32'h0F05);
        wr(4'd5, 16'hE6E4);
        rd(4'd5, rv); chk("R5 ctrl1 ignored bits", {16'h0, rv}, 32'h0604);

        // R6 rising edge on out0 (interrupt mode)
        @(negedge clk); in_trig = 16'h0001;
        @(negedge clk);
        rd(4'd4, rv); chk("R6 not yet", {16'h0, rv}, 32'h0F05);
        @(negedge clk);
        rd(4'd4, rv); chk("R6 rise flag", {16'h0, rv}, 32'h0F15);
        chk("R8 irq", {28'h0, irq_req}, 32'h1);
        chk("R8 no dma", {28'h0, dma_req}, 32'h0);

        // R7 zero write keeps flag
        wr(4'd4, 16'h0F05);
        rd(4'd4, rv); chk("R7 zero keeps", {16'h0, rv}, 32'h0F15);

        // R9 ack ignored in interrupt mode
        ack_pulse(4'b0001);
        rd(4'd4, rv); chk("R9 ack ignored irq", {16'h0, rv}, 32'h0F15);

        // R7 write one clears
        wr(4'd4, 16'h0F15);
        rd(4'd4, rv); chk("R7 w1c", {16'h0, rv}, 32'h0F05);
        chk("R7 irq gone", {28'h0, irq_req}, 32'h0);

        // R6 falling edge ignored in rise mode
        @(negedge clk); in_trig = 16'h0000;
        wait_n(3);
        rd(4'd4, rv); chk("R6 fall ignored", {16'h0, rv}, 32'h0F05);

        // R7 edge in same cycle as clear wins
        @(negedge clk); in_trig = 16'h0001;
        wr(4'd4, 16'h0F15);
        rd(4'd4, rv); chk("R7 edge wins", {16'h0, rv}, 32'h0F15);
        wr(4'd4, 16'h0F15);
        rd(4'd4, rv); chk("R7 cleared", {16'h0, rv}, 32'h0F05);

        // R6/R8/R9 out1 both edges in DMA mode
        @(negedge clk); in_trig = 16'h0003;
        wait_n(2);
        rd(4'd4, rv); chk("R6 both rise", {16'h0, rv}, 32'h1F05);
        chk("R8 dma", {28'h0, dma_req}, 32'h2);
        chk("R8 no irq", {28'h0, irq_req}, 32'h0);
        ack_pulse(4'b0010);
        rd(4'd4, rv); chk("R9 ack clears", {16'h0, rv}, 32'h0F05);
        chk("R9 dma gone", {28'h0, dma_req}, 32'h0);
        @(negedge clk); in_trig = 16'h0001;
        wait_n(2);
        rd(4'd4, rv); chk("R6 both fall", {16'h0, rv}, 32'h1F05);
        ack_pulse(4'b0010);

        // R6 mode off on out2
        @(negedge clk); in_trig = 16'h0005;
        wait_n(3);
        rd(4'd5, rv); chk("R6 mode off", {16'h0, rv}, 32'h0604);
        chk("R6 no irq2", {28'h0, irq_req}, 32'h0);

        // R6 falling edge on out3
        @(negedge clk); in_trig = 16'h000D;
        wait_n(3);
        rd(4'd5, rv); chk("R6 rise ignored fall mode", {16'h0, rv}, 32'h0604);
        @(negedge clk); in_trig = 16'h0005;
        wait_n(2);
        rd(4'd5, rv); chk("R6 fall flag", {16'h0, rv}, 32'h1604);
        chk("R8 irq3", {28'h0, irq_req}, 32'h8);

        // R8 requests disabled: flag sets, no request
        wr(4'd5, 16'h1601);
        @(negedge clk); in_trig = 16'h0001;
        wait_n(3);
        @(negedge clk); in_trig = 16'h0005;
        wait_n(2);
        rd(4'd5, rv); chk("R8 disabled flag", {16'h0, rv}, 32'h0611);
        chk("R8 disabled irq", {28'h0, irq_req}, 32'h0);
        chk("R8 disabled dma", {28'h0, dma_req}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule